// File: doc/BRIEF.md
# Pipelined Pixel Bus Transfer Driver

This block moves converted pixel values from an acquisition board onto a shared backplane pixel bus. When pipeline operation is enabled, each conversion strobe makes the block claim the bus through an 8-line request bus that behaves like an open-drain bus. All lines on that bus are pulled high when idle. The block sends a configured number of 48-bit words and then gives the bus back. To get clean edges on the request lines, it drives them actively high before it lets go of them. Every phase of the claim and release handshake lasts a fixed number of clock cycles, and those counts are parameters.

Each 48-bit word holds two 18-bit pixels in 24-bit lanes, with the high pixel in the upper lane. A 2-bit select picks which 16 bits of each pixel are sent, or sends all 18. When exactly one word per request is configured, the block works in a pairing mode. In that mode only every second strobe starts a transfer, and that one word carries the pixel from the previous strobe together with the newest one. A request counter and a transferred-pixel counter record the traffic, and a start-exposure pulse clears them. If a strobe arrives while the bus is still in use, it is remembered and served as soon as the bus has been released.

Top module: `pixbus_xfer_drv`

## Requirements
- R1: While reset is held, and immediately after it, the request bus is not driven, `pix_oe`, `pix_xmit` and `busy` are low, `pix_data` is zero, and both counters are zero.
- R2: An accepted request drives all eight request lines high for SHORT_CYC cycles (default 1). It then pulls only the line with index `slot_id` low for LONG_CYC cycles (default 2). After that it also pulls line 7 low.
- R3: With line 7 and the slot line both low, the block sends exactly `xfer_cnt` words, one per cycle. During those cycles `pix_oe` and `pix_xmit` are high, and word k is built from `rd_hi_pix` and `rd_lo_pix` while `rd_idx` = k. Outside these cycles `pix_data` is zero.
- R4: After the last word, line 7 returns high while the slot line stays low, for LONG_CYC cycles. Then all lines are driven high for SHORT_CYC cycles. Then the request bus stops being driven.
- R5: The high pixel goes in `pix_data[47:24]` and the low pixel in `pix_data[23:0]`. Each lane is zero-extended from pixel bits [15:0] when `data_sel`=0, from [16:1] when it is 1, and from [17:2] when it is 2. When `data_sel`=3 the lane holds all 18 bits, zero-extended.
- R6: When `pipe_en`=1 and `xfer_cnt`=1, strobes alternate. The first stores `new_pix`. The second starts a one-word transfer with the stored pixel as the high pixel and its own `new_pix` as the low pixel.
- R7: A strobe has no effect while `pipe_en`=0 or while `xfer_cnt`=0.
- R8: A request begins only after the registered copy of `req_in` has read all ones. Until then the block stays busy without driving the bus.
- R9: `req_count` rises by one for each request started, and `pix_count` grows by `xfer_cnt` for each request started. A `start_exp` pulse clears both.
- R10: `busy` is high from the cycle after an accepted strobe until the release sequence finishes.
- R11: A strobe accepted during a transfer is served by one more transfer right after the release. Any further strobes in the same transfer merge into that single pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctc | input | 1 | Conversion strobe, one cycle |
| new_pix | input | 18 | Newest pixel, taken with the strobe in pairing mode |
| pipe_en | input | 1 | Pipeline transfer enable |
| xfer_cnt | input | 8 | Words per request |
| data_sel | input | 2 | Lane packing select |
| slot_id | input | 3 | Index of this board's request line (0 to 6) |
| start_exp | input | 1 | Clears the audit counters |
| req_in | input | 8 | Sampled level of the request bus |
| rd_hi_pix | input | 18 | High pixel of the word at `rd_idx` |
| rd_lo_pix | input | 18 | Low pixel of the word at `rd_idx` |
| rd_idx | output | 8 | Index of the word being sent |
| req_out | output | 8 | Levels driven onto the request bus |
| req_oe | output | 1 | Request bus drive enable |
| pix_data | output | 48 | Pixel bus data |
| pix_oe | output | 1 | Pixel bus drive enable |
| pix_xmit | output | 1 | High while words are on the pixel bus |
| busy | output | 1 | Transfer in progress |
| req_count | output | 16 | Requests made |
| pix_count | output | 24 | Accumulated transfer count |

## Verification
The bench measures the length of every phase of the request handshake. A timer that is off by one would show up as a phase one cycle too long or too short, and a wrong release order would show line 7 and the slot line changing together. All four packing selects are tried with pixels whose top bits differ, so a shifted or swapped lane produces a word mismatch. Pairing mode is driven through two pairs, which exposes a swapped old/new order or a transfer on every strobe. Strobes are also sent while the bus is held by another board, while transfers are disabled, and during an ongoing transfer. A design that lost, duplicated or failed to merge a pending request would show the wrong number of transfers and wrong counter totals.

// File: rtl/pixbus_pkg.sv
package pixbus_pkg;

    localparam int REQ_W    = 8;
    localparam int PIX_W    = 18;
    localparam int LANE_W   = 24;
    localparam int WORD_W   = 2 * LANE_W;
    localparam int NARROW_W = 16;
    localparam int SEL_W    = 2;
    localparam int SLOT_W   = $clog2(REQ_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_LEAD_HI,
        ST_CLAIM,
        ST_SEND,
        ST_DROP_GRANT,
        ST_TAIL_HI
    } xfer_state_e;

    typedef struct packed {
        logic [PIX_W-1:0] hi;
        logic [PIX_W-1:0] lo;
    } pix_pair_t;

    typedef struct packed {
        logic             drive;
        logic [REQ_W-1:0] level;
    } req_drive_t;

    // Place one pixel into a 24-bit lane according to the packing select.
    function automatic logic [LANE_W-1:0] pack_lane(input logic [SEL_W-1:0] sel,
                                                    input logic [PIX_W-1:0] p);
        logic [LANE_W-1:0] r;
        r = '0;
        unique case (sel)
            2'd0:    r[NARROW_W-1:0] = p[NARROW_W-1:0];
            2'd1:    r[NARROW_W-1:0] = p[NARROW_W:1];
            2'd2:    r[NARROW_W-1:0] = p[NARROW_W+1:2];
            default: r[PIX_W-1:0]    = p;
        endcase
        return r;
    endfunction

    function automatic logic [REQ_W-1:0] slot_mask(input logic [SLOT_W-1:0] s);
        return REQ_W'(1) << s;
    endfunction

endpackage

// File: rtl/pxd_trigger.sv
module pxd_trigger
    import pixbus_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctc,
    input  logic                 pipe_en,
    input  logic [CNT_W-1:0]     xfer_cnt,
    input  logic [PIX_W-1:0]     new_pix,
    output logic                 fire,
    output logic                 pair_mode,
    output pix_pair_t            pair
);

    logic             phase_q;
    logic [PIX_W-1:0] held_q;

    assign pair_mode = pipe_en && (xfer_cnt == CNT_W'(1));

    // Qualified strobe: enabled, non-zero count, and in pairing mode only the second of two.
    assign fire = ctc && pipe_en && (xfer_cnt != '0) && (!pair_mode || phase_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            held_q  <= '0;
            pair    <= '0;
        end else if (!pair_mode) begin
            phase_q <= 1'b0;
        end else if (ctc) begin
            if (!phase_q) begin
                held_q  <= new_pix;
                phase_q <= 1'b1;
            end else begin
                pair.hi <= held_q;
                pair.lo <= new_pix;
                phase_q <= 1'b0;
            end
        end
    end

    // R6: a pairing-mode strobe that starts a transfer is always the second of a pair
    AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (rst)
        (fire && pair_mode) |=> !phase_q); // R6

endmodule

// File: rtl/pxd_seq.sv
module pxd_seq
    import pixbus_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SHORT_CYC = 1,
    parameter int LONG_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic              pair_mode,
    input  logic [CNT_W-1:0]  xfer_cnt,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic [REQ_W-1:0]  req_in,
    output logic [REQ_W-1:0]  req_out,
    output logic              req_oe,
    output logic              send,
    output logic              busy,
    output logic [CNT_W-1:0]  widx,
    output logic              start,
    output logic              mode_lat
);

    localparam int MAX_DLY = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int TMR_W   = (MAX_DLY > 1) ? $clog2(MAX_DLY) : 1;
    localparam logic [TMR_W-1:0] SHORT_END = TMR_W'(SHORT_CYC - 1);
    localparam logic [TMR_W-1:0] LONG_END  = TMR_W'(LONG_CYC - 1);
    localparam logic [REQ_W-1:0] GRANT_BIT = REQ_W'(1) << (REQ_W - 1);

    xfer_state_e      state_q;
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] n_lat_q;
    logic [REQ_W-1:0] req_q;
    logic             pend_q;
    logic             last_word;
    req_drive_t       drv;

    assign start     = (state_q == ST_IDLE) && (fire || pend_q);
    assign last_word = ({1'b0, widx} + (CNT_W+1)'(1)) >= {1'b0, n_lat_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tmr_q    <= '0;
            widx     <= '0;
            n_lat_q  <= '0;
            mode_lat <= 1'b0;
            req_q    <= '1;
            pend_q   <= 1'b0;
        end else begin
            req_q <= req_in;

            if (start)     pend_q <= pend_q && fire;
            else if (fire) pend_q <= 1'b1;

            unique case (state_q)
                ST_IDLE: begin
                    widx <= '0;
                    if (start) begin
                        state_q  <= ST_WAIT_FREE;
                        n_lat_q  <= xfer_cnt;
                        mode_lat <= pair_mode;
                    end
                end
                ST_WAIT_FREE: begin
                    if (req_q == '1) begin
                        state_q <= ST_LEAD_HI;
                        tmr_q   <= '0;
                    end
                end
                ST_LEAD_HI: begin
                    if (tmr_q == SHORT_END) begin
                        state_q <= ST_CLAIM;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_CLAIM: begin
                    if (tmr_q == LONG_END) begin
                        state_q <= ST_SEND;
                        tmr_q   <= '0;
                        widx    <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_SEND: begin
                    if (last_word) begin
                        state_q <= ST_DROP_GRANT;
                        tmr_q   <= '0;
                    end else begin
                        widx <= widx + 1'b1;
                    end
                end
                ST_DROP_GRANT: begin
                    if (tmr_q == LONG_END) begin
                        state_q <= ST_TAIL_HI;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                ST_TAIL_HI: begin
                    if (tmr_q == SHORT_END) begin
                        state_q <= ST_IDLE;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        drv.drive = 1'b1;
        drv.level = '1;
        unique case (state_q)
            ST_IDLE, ST_WAIT_FREE:     drv.drive = 1'b0;
            ST_LEAD_HI, ST_TAIL_HI:    drv.level = '1;
            ST_CLAIM, ST_DROP_GRANT:   drv.level = ~slot_mask(slot_id);
            ST_SEND:                   drv.level = ~(slot_mask(slot_id) | GRANT_BIT);
            default:                   drv.drive = 1'b0;
        endcase
    end

    assign req_out = drv.level;
    assign req_oe  = drv.drive;
    assign send    = (state_q == ST_SEND);
    assign busy    = (state_q != ST_IDLE);

    AST_LEAD_ALL_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(req_oe) |-> (req_out == '1)); // R2

    AST_TAIL_ALL_HIGH: assert property (@(posedge clk) disable iff (rst)
        $fell(req_oe) |-> ($past(req_out) == '1)); // R4

    AST_SEND_GRANTED: assert property (@(posedge clk) disable iff (rst)
        send |-> (req_oe && !req_out[REQ_W-1] && !req_out[slot_id])); // R3

    AST_DRIVE_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_oe |-> busy); // R10

    AST_CLAIM_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        $rose(req_oe) |-> ($past(req_q) == '1)); // R8

endmodule

// File: rtl/pxd_pack.sv
module pxd_pack
    import pixbus_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  pix_pair_t         src,
    output logic [WORD_W-1:0] word
);

    logic [PIX_W-1:0] lane_pix [2];

    assign lane_pix[0] = src.lo;
    assign lane_pix[1] = src.hi;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign word[g*LANE_W +: LANE_W] = pack_lane(sel, lane_pix[g]);
    end

endmodule

// File: rtl/pxd_audit.sv
module pxd_audit #(
    parameter int CNT_W    = 8,
    parameter int REQCNT_W = 16,
    parameter int PIXCNT_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                start,
    input  logic [CNT_W-1:0]    add_val,
    output logic [REQCNT_W-1:0] req_count,
    output logic [PIXCNT_W-1:0] pix_count
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            req_count <= '0;
            pix_count <= '0;
        end else if (start) begin
            req_count <= req_count + 1'b1;
            pix_count <= pix_count + PIXCNT_W'(add_val);
        end
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (req_count == '0 && pix_count == '0)); // R9

endmodule

// File: rtl/pixbus_xfer_drv.sv
module pixbus_xfer_drv
    import pixbus_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SHORT_CYC = 1,
    parameter int LONG_CYC  = 2,
    parameter int REQCNT_W  = 16,
    parameter int PIXCNT_W  = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ctc,
    input  logic [17:0]         new_pix,
    input  logic                pipe_en,
    input  logic [CNT_W-1:0]    xfer_cnt,
    input  logic [1:0]          data_sel,
    input  logic [2:0]          slot_id,
    input  logic                start_exp,
    input  logic [7:0]          req_in,
    input  logic [17:0]         rd_hi_pix,
    input  logic [17:0]         rd_lo_pix,
    output logic [CNT_W-1:0]    rd_idx,
    output logic [7:0]          req_out,
    output logic                req_oe,
    output logic [47:0]         pix_data,
    output logic                pix_oe,
    output logic                pix_xmit,
    output logic                busy,
    output logic [REQCNT_W-1:0] req_count,
    output logic [PIXCNT_W-1:0] pix_count
);

    logic        fire;
    logic        pair_mode;
    logic        send;
    logic        start;
    logic        mode_lat;
    pix_pair_t   pair;
    pix_pair_t   src;
    logic [47:0] packed_word;

    pxd_trigger #(.CNT_W(CNT_W)) u_trigger (
        .clk       (clk),
        .rst       (rst),
        .ctc       (ctc),
        .pipe_en   (pipe_en),
        .xfer_cnt  (xfer_cnt),
        .new_pix   (new_pix),
        .fire      (fire),
        .pair_mode (pair_mode),
        .pair      (pair)
    );

    pxd_seq #(
        .CNT_W     (CNT_W),
        .SHORT_CYC (SHORT_CYC),
        .LONG_CYC  (LONG_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .pair_mode (pair_mode),
        .xfer_cnt  (xfer_cnt),
        .slot_id   (slot_id),
        .req_in    (req_in),
        .req_out   (req_out),
        .req_oe    (req_oe),
        .send      (send),
        .busy      (busy),
        .widx      (rd_idx),
        .start     (start),
        .mode_lat  (mode_lat)
    );

    always_comb begin
        if (mode_lat) begin
            src = pair;
        end else begin
            src.hi = rd_hi_pix;
            src.lo = rd_lo_pix;
        end
    end

    pxd_pack u_pack (
        .sel  (data_sel),
        .src  (src),
        .word (packed_word)
    );

    pxd_audit #(
        .CNT_W    (CNT_W),
        .REQCNT_W (REQCNT_W),
        .PIXCNT_W (PIXCNT_W)
    ) u_audit (
        .clk       (clk),
        .rst       (rst),
        .clr       (start_exp),
        .start     (start),
        .add_val   (xfer_cnt),
        .req_count (req_count),
        .pix_count (pix_count)
    );

    assign pix_data = send ? packed_word : '0;
    assign pix_oe   = send;
    assign pix_xmit = send;

    AST_QUIET_DATA: assert property (@(posedge clk) disable iff (rst)
        !pix_oe |-> (pix_data == '0)); // R3

endmodule

// File: tb/test_pixbus_xfer_drv.sv
module test_pixbus_xfer_drv;

    localparam int SHORT = 1;
    localparam int LONG  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctc = 1'b0;
    logic [17:0] new_pix = '0;
    logic        pipe_en = 1'b1;
    logic [7:0]  xfer_cnt = 8'd3;
    logic [1:0]  data_sel = 2'd0;
    logic [2:0]  slot_id = 3'd5;
    logic        start_exp = 1'b0;
    logic [7:0]  req_in = 8'hFF;
    logic [17:0] rd_hi_pix, rd_lo_pix;
    logic [7:0]  rd_idx, req_out;
    logic        req_oe, pix_oe, pix_xmit, busy;
    logic [47:0] pix_data;
    logic [15:0] req_count;
    logic [23:0] pix_count;

    int total = 0, bad = 0, cyc = 0, n_xfers = 0, frame = 1;
    int exp_req = 0, exp_pix = 0;
    bit done = 0, bphase = 0;
    logic [17:0] bold = '0;
    logic [47:0] word_q[$];
    int          len_q[$];

    always #10 clk = ~clk;

    function automatic logic [17:0] src_hi(int f, int k);
        return 18'(f * 4099 + k * 7919 + 'h2C3A5);
    endfunction
    function automatic logic [17:0] src_lo(int f, int k);
        return 18'(f * 613 + k * 12289 + 'h31F0B);
    endfunction
    // R5 lane mapping
    function automatic logic [23:0] lane(logic [1:0] s, logic [17:0] p);
        case (s)
            2'd0: return {8'h00, p[15:0]};
            2'd1: return {8'h00, p[16:1]};
            2'd2: return {8'h00, p[17:2]};
            default: return {6'b0, p};
        endcase
    endfunction

    assign rd_hi_pix = src_hi(frame, int'(rd_idx));
    assign rd_lo_pix = src_lo(frame, int'(rd_idx));

    pixbus_xfer_drv i_pixbus_xfer_drv (
        .clk(clk), .rst(rst), .ctc(ctc), .new_pix(new_pix), .pipe_en(pipe_en),
        .xfer_cnt(xfer_cnt), .data_sel(data_sel), .slot_id(slot_id),
        .start_exp(start_exp), .req_in(req_in), .rd_hi_pix(rd_hi_pix),
        .rd_lo_pix(rd_lo_pix), .rd_idx(rd_idx), .req_out(req_out), .req_oe(req_oe),
        .pix_data(pix_data), .pix_oe(pix_oe), .pix_xmit(pix_xmit), .busy(busy),
        .req_count(req_count), .pix_count(pix_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: pulses a strobe and pushes the expected results to the scoreboard.
    task automatic strobe(input logic [17:0] pix, input bit expect_it);
        @(posedge clk) #2;
        ctc = 1'b1;
        new_pix = pix;
        if (expect_it && pipe_en && xfer_cnt != 0) begin
            if (xfer_cnt == 8'd1) begin
                if (bphase) begin
                    word_q.push_back({lane(data_sel, bold), lane(data_sel, pix)});
                    len_q.push_back(1);
                    exp_req++; exp_pix += 1; bphase = 0;
                end else begin
                    bold = pix; bphase = 1;
                end
            end else begin
                for (int k = 0; k < int'(xfer_cnt); k++)
                    word_q.push_back({lane(data_sel, src_hi(frame, k)), lane(data_sel, src_lo(frame, k))});
                len_q.push_back(int'(xfer_cnt));
                exp_req++; exp_pix += int'(xfer_cnt);
            end
        end
        @(posedge clk) #2;
        ctc = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (busy || req_oe) quiet = 0; else quiet++;
        end
    endtask

    // Monitor: pops expected words and checks the handshake phase lengths.
    int prev_code = 0, nph = 0;
    int ph_code[8], ph_len[8];
    always @(negedge clk) begin
        int code;
        logic [7:0] sl;
        if (!rst) begin
            sl = ~(8'd1 << slot_id);
            if (!req_oe) code = 0;
            else if (req_out == 8'hFF) code = 1;
            else if (req_out == sl) code = 2;
            else if (req_out == (sl & 8'h7F)) code = 3;
            else code = 4;
            if (pix_xmit) begin
                if (word_q.size() == 0) check(0, "R3 unexpected word", pix_data, 0);
                else begin
                    logic [47:0] e;
                    e = word_q.pop_front();
                    check(pix_data == e && pix_oe, "R5 word", pix_data, e);
                end
            end
            if (code != 0) begin
                if (code != prev_code) begin
                    nph++;
                    if (nph <= 8) begin ph_code[nph-1] = code; ph_len[nph-1] = 1; end
                end else if (nph >= 1 && nph <= 8) ph_len[nph-1]++;
            end else if (prev_code != 0) begin
                int n;
                n_xfers++;
                n = (len_q.size() > 0) ? len_q.pop_front() : -1;
                check(nph == 5 && ph_code[0] == 1 && ph_len[0] == SHORT && ph_code[1] == 2 &&
                      ph_len[1] == LONG, "R2 lead phases", ph_len[1], LONG);
                check(nph == 5 && ph_code[2] == 3 && ph_len[2] == n, "R3 word count", ph_len[2], n);
                check(nph == 5 && ph_code[3] == 2 && ph_len[3] == LONG && ph_code[4] == 1 &&
                      ph_len[4] == SHORT, "R4 release phases", ph_len[3], LONG);
                nph = 0;
            end
            prev_code = code;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            check(0, "watchdog expired", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1
        check(!req_oe && !pix_oe && !pix_xmit && !busy, "R1 idle outputs", {req_oe, pix_oe, busy}, 0);
        check(pix_data == 0 && req_count == 0 && pix_count == 0, "R1 zero data/counters", pix_data, 0);
        @(posedge clk) #2 rst = 1'b0;
        @(negedge clk);
        check(!busy && !req_oe && req_count == 0, "R1 after release", busy, 0);

        // R10 busy and basic transfer
        strobe(18'h12345, 1);
        check(busy && !req_oe, "R10 busy after strobe", busy, 1);
        wait_idle();
        check(!busy, "R10 busy drops", busy, 0);

        // R5 packing selects
        for (int s = 1; s < 4; s++) begin
            data_sel = 2'(s); frame = s + 7;
            strobe(18'h0, 1);
            wait_idle();
        end
        xfer_cnt = 8'd2; frame = 20;
        strobe(18'h0, 1);
        wait_idle();

        // R7 ignored strobes
        base = n_xfers;
        pipe_en = 1'b0;
        strobe(18'h1, 1);
        repeat (20) @(negedge clk);
        check(n_xfers == base && req_count == 16'(exp_req) && !busy, "R7 pipe disabled", n_xfers, base);
        pipe_en = 1'b1; xfer_cnt = 8'd0;
        strobe(18'h1, 1);
        repeat (20) @(negedge clk);
        check(n_xfers == base && req_count == 16'(exp_req) && !busy, "R7 zero count", n_xfers, base);
        xfer_cnt = 8'd3;

        // R8 bus held by another board
        req_in = 8'h7F;
        strobe(18'h0, 1);
        repeat (10) @(negedge clk);
        check(!req_oe && busy, "R8 waits while bus held", req_oe, 0);
        req_in = 8'hFF;
        wait_idle();
        check(n_xfers == base + 1, "R8 proceeds when free", n_xfers, base + 1);

        // R11 pending and coalescing
        base = n_xfers;
        strobe(18'h0, 1);
        repeat (3) @(posedge clk);
        strobe(18'h0, 1);
        wait_idle();
        check(n_xfers == base + 2, "R11 pending served", n_xfers, base + 2);
        base = n_xfers;
        strobe(18'h0, 1);
        repeat (2) @(posedge clk);
        strobe(18'h0, 1);
        strobe(18'h0, 0);
        wait_idle();
        check(n_xfers == base + 2, "R11 coalesced", n_xfers, base + 2);

        // R6 pairing mode
        base = n_xfers;
        xfer_cnt = 8'd1; data_sel = 2'd3; bphase = 0;
        strobe(18'h3A5C1, 1); wait_idle();
        check(n_xfers == base, "R6 first of pair silent", n_xfers, base);
        strobe(18'h05E72, 1); wait_idle();
        strobe(18'h2FFFF, 1); wait_idle();
        strobe(18'h10001, 1); wait_idle();
        check(n_xfers == base + 2, "R6 every second strobe", n_xfers, base + 2);
        data_sel = 2'd0; xfer_cnt = 8'd3;

        // R9 counters
        check(req_count == 16'(exp_req), "R9 request count", req_count, exp_req);
        check(pix_count == 24'(exp_pix), "R9 pixel count", pix_count, exp_pix);
        @(posedge clk) #2 start_exp = 1'b1;
        @(posedge clk) #2 start_exp = 1'b0;
        @(negedge clk);
        check(req_count == 0 && pix_count == 0, "R9 clear", req_count, 0);

        check(word_q.size() == 0 && len_q.size() == 0, "R3 all words seen", word_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule